// File: doc/BRIEF.md
# Shift-Register Video Timing Generator

This block produces the raster timing for a display pipe: horizontal sync, vertical sync, a display-enable window and a one-cycle frame marker. It does not count pixels and lines with binary adders. It keeps its horizontal and vertical positions in two 16-bit linear feedback shift registers. Each register advances one state per pixel clock or per line. Every comparator is a plain 16-bit equality test, so the logic between registers stays shallow whatever the raster size.

Software, or a mode-setting engine, therefore programs every limit as the shift-register state reached after N steps from the all-ones seed, and not as N itself. Each line begins with the sync pulse. Active video starts at step (total − sync start) and runs for the active count. The horizontal wrap limit is the state at step (total − 1). A one-byte control code turns the outputs on (code 0x00) or holds them idle (any other code). The counters keep running while the outputs are idle, so turning them back on needs no realignment.

Top module: `lfsr_tg_timing`

## Requirements
- R1: While rst_n is low, hsync_o, vsync_o, de_o and frame_start_o are 0. Both position registers hold the seed 0xFFFF, so the first rising edge after reset releases reports position (step 0, line 0).
- R2: A position register steps by shifting left one place. The new bit 0 is the XOR of old bits 15, 4, 2 and 1. A limit programmed as the state after N steps is therefore reached N clocks (or lines) after the seed.
- R3: When the horizontal register equals h_last_i, it reloads 0xFFFF on the next clock. A line therefore lasts (steps to h_last_i) + 1 pixel clocks.
- R4: The vertical register advances one step only on a clock where the horizontal register wraps. It reloads 0xFFFF on the horizontal wrap where it equals v_last_i.
- R5: The hsync flag is set on the clock where the horizontal state equals h_sync_on_i and cleared where it equals h_sync_off_i. With on = step 1 and off = step (w+1), hsync is high for pixel steps 1..w.
- R6: The vsync flag is set where the vertical state equals v_sync_on_i and cleared where it equals v_sync_off_i. With on = step 0 and off = step w, vsync is high for lines 0..w−1.
- R7: de_o is high when both the horizontal active flag (h_act_start_i .. h_act_stop_i) and the vertical active flag (v_act_start_i .. v_act_stop_i) are set. Each active flag is set on its start match and cleared on its stop match.
- R8: When ctrl_i is 0x00, the outputs follow the flags. For any other code (for example 0x01 or 0x07), hsync_o, vsync_o and de_o are 0 on the next clock, and the position registers keep advancing.
- R9: frame_start_o is high for exactly one clock per frame, at the position where both registers hold 0xFFFF, whatever the value of ctrl_i.
- R10: If a flag's start and stop states are equal, the stop match wins and the flag stays low.
- R11: Every output is registered. An output reflects the counter position of the clock edge that produced it, one cycle after that position is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 8 | Output control code: 0x00 drives, any other code holds idle |
| h_act_start_i | input | 16 | Horizontal state where active video starts |
| h_act_stop_i | input | 16 | Horizontal state where active video stops |
| h_last_i | input | 16 | Horizontal state at the last pixel of a line |
| h_sync_on_i | input | 16 | Horizontal state where hsync rises |
| h_sync_off_i | input | 16 | Horizontal state where hsync falls |
| v_act_start_i | input | 16 | Vertical state where active lines start |
| v_act_stop_i | input | 16 | Vertical state where active lines stop |
| v_last_i | input | 16 | Vertical state at the last line of a frame |
| v_sync_on_i | input | 16 | Vertical state where vsync rises |
| v_sync_off_i | input | 16 | Vertical state where vsync falls |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Display enable |
| frame_start_o | output | 1 | One-clock pulse at the first pixel of a frame |

## Verification
The bench programs limits through its own step-by-step conversion from binary counts and compares every output on every cycle against a binary-counting model. Wrong feedback taps or an off-by-one wrap therefore show up as lines of the wrong length, or as windows that slide from frame to frame. Small rasters exercise the wrap at both counters and the vertical advance that must happen only on a line wrap; a design that stepped the vertical register on every pixel would place vsync and the active lines in the wrong rows. The control code is switched among 0x00, 0x01, 0x07 and other codes in the middle of frames, to catch outputs that leak while idle or counters that stall while idle. A setting with equal start and stop states catches a set-over-clear priority, because such a design raises hsync on every line.

// File: rtl/lfsr_tg_pkg.sv
package lfsr_tg_pkg;
  localparam int LW = 16;
  localparam int CW = 8;
  localparam int NWIN = 4;
  typedef logic [LW-1:0] lstate_t;
  localparam lstate_t SEED = '1;
  localparam lstate_t DEF_TAPS = 16'h8016;
  localparam logic [CW-1:0] CTRL_ON = 8'h00;

  // one step: shift left, feedback = parity of the tapped bits
  function automatic lstate_t lfsr_next(input lstate_t s, input lstate_t taps);
    return {s[LW-2:0], ^(s & taps)};
  endfunction
endpackage

// File: rtl/lfsr_tg_counter.sv
module lfsr_tg_counter
  import lfsr_tg_pkg::*;
#(
  parameter lstate_t TAPS = DEF_TAPS
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv_i,
  input  lstate_t last_i,
  output lstate_t state_o,
  output logic    wrap_o
);
  lstate_t state_q;
  logic    at_last;

  assign at_last = (state_q == last_i);
  assign wrap_o  = adv_i && at_last;
  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= SEED;
    else if (wrap_o)  state_q <= SEED;
    else if (adv_i)   state_q <= lfsr_next(state_q, TAPS);
  end

  // the all-zero state is a lock-up point and never reachable from the seed
  assert_never_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(state_q));
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> state_q == SEED);
endmodule

// File: rtl/lfsr_tg_window.sv
module lfsr_tg_window
  import lfsr_tg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  lstate_t state_i,
  input  lstate_t start_i,
  input  lstate_t stop_i,
  output logic    nxt_o
);
  logic q;
  logic hit_start, hit_stop;

  assign hit_start = (state_i == start_i);
  assign hit_stop  = (state_i == stop_i);

  always_comb begin
    if (hit_stop)       nxt_o = 1'b0;
    else if (hit_start) nxt_o = 1'b1;
    else                nxt_o = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt_o;
  end

  assert_clear_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stop |=> !q);
  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_start && !hit_stop) |=> q);
endmodule

// File: rtl/lfsr_tg_timing.sv
module lfsr_tg_timing
  import lfsr_tg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctrl_i,
  input  logic [LW-1:0] h_act_start_i,
  input  logic [LW-1:0] h_act_stop_i,
  input  logic [LW-1:0] h_last_i,
  input  logic [LW-1:0] h_sync_on_i,
  input  logic [LW-1:0] h_sync_off_i,
  input  logic [LW-1:0] v_act_start_i,
  input  logic [LW-1:0] v_act_stop_i,
  input  logic [LW-1:0] v_last_i,
  input  logic [LW-1:0] v_sync_on_i,
  input  logic [LW-1:0] v_sync_off_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          frame_start_o
);
  // window slots: 0 hsync, 1 h active, 2 vsync, 3 v active
  localparam int W_HS = 0;
  localparam int W_HA = 1;
  localparam int W_VS = 2;
  localparam int W_VA = 3;

  lstate_t h_state, v_state;
  logic    h_wrap, v_wrap;
  logic    out_en;
  logic    at_origin;
  lstate_t win_state [NWIN];
  lstate_t win_start [NWIN];
  lstate_t win_stop  [NWIN];
  logic [NWIN-1:0] win_nxt;
  logic    hs_q, vs_q, de_q, fs_q;

  lfsr_tg_counter #(.TAPS(DEF_TAPS)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .adv_i(1'b1), .last_i(h_last_i),
    .state_o(h_state), .wrap_o(h_wrap)
  );

  lfsr_tg_counter #(.TAPS(DEF_TAPS)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .adv_i(h_wrap), .last_i(v_last_i),
    .state_o(v_state), .wrap_o(v_wrap)
  );

  assign win_state[W_HS] = h_state;
  assign win_start[W_HS] = h_sync_on_i;
  assign win_stop[W_HS]  = h_sync_off_i;
  assign win_state[W_HA] = h_state;
  assign win_start[W_HA] = h_act_start_i;
  assign win_stop[W_HA]  = h_act_stop_i;
  assign win_state[W_VS] = v_state;
  assign win_start[W_VS] = v_sync_on_i;
  assign win_stop[W_VS]  = v_sync_off_i;
  assign win_state[W_VA] = v_state;
  assign win_start[W_VA] = v_act_start_i;
  assign win_stop[W_VA]  = v_act_stop_i;

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    lfsr_tg_window u_win (
      .clk(clk), .rst_n(rst_n), .state_i(win_state[gi]),
      .start_i(win_start[gi]), .stop_i(win_stop[gi]), .nxt_o(win_nxt[gi])
    );
  end

  assign out_en    = (ctrl_i == CTRL_ON);
  assign at_origin = (h_state == SEED) && (v_state == SEED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
      fs_q <= 1'b0;
    end else begin
      hs_q <= out_en & win_nxt[W_HS];
      vs_q <= out_en & win_nxt[W_VS];
      de_q <= out_en & win_nxt[W_HA] & win_nxt[W_VA];
      fs_q <= at_origin;
    end
  end

  assign hsync_o       = hs_q;
  assign vsync_o       = vs_q;
  assign de_o          = de_q;
  assign frame_start_o = fs_q;

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i != CTRL_ON) |=> !(hsync_o || vsync_o || de_o));
  assert_v_on_line_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    v_wrap |-> h_wrap);
  assert_fs_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_o && !(h_last_i == SEED && v_last_i == SEED)) |=> !frame_start_o);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !(hsync_o || vsync_o || de_o || frame_start_o));
endmodule

// File: tb/lfsr_tg_timing_bench.sv
`timescale 1ns/1ps
module lfsr_tg_timing_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctrl = 8'h00;
  logic [15:0] h_as, h_ae, h_last, h_on, h_off;
  logic [15:0] v_as, v_ae, v_last, v_on, v_off;
  logic        hs, vs, de, fs;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lfsr_tg_timing u_lfsr_tg_timing (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl),
    .h_act_start_i(h_as), .h_act_stop_i(h_ae), .h_last_i(h_last),
    .h_sync_on_i(h_on), .h_sync_off_i(h_off),
    .v_act_start_i(v_as), .v_act_stop_i(v_ae), .v_last_i(v_last),
    .v_sync_on_i(v_on), .v_sync_off_i(v_off),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .frame_start_o(fs)
  );

  // binary count -> state after n steps from the all-ones seed (R2)
  function automatic logic [15:0] to_state(input int n);
    int s = 65535;
    for (int i = 0; i < n; i++) begin
      int fb = ((s / 32768) + (s / 16) + (s / 4) + (s / 2)) % 2;
      s = ((s * 2) % 65536) + fb;
    end
    return s[15:0];
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] pick_ctrl(input int k);
    case (k % 4)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h07;
      default: return 8'h02 + 8'($urandom % 200);
    endcase
  endfunction

  // run one raster; ctrl_mode 0 keeps ctrl at 0x00, 1 switches it mid-frame
  task automatic run_cfg(input int ht, input int hsw, input int hds, input int hact,
                         input int vt, input int vsw, input int vds, input int vact,
                         input bit hs_dead, input int nframes, input int ctrl_mode);
    int p = 0;
    int l = 0;
    logic e_hs, e_vs, e_de, e_fs, en;
    rst_n = 1'b0;
    ctrl  = 8'h00;
    h_last = to_state(ht - 1);
    h_on   = hs_dead ? to_state(3) : to_state(1);
    h_off  = hs_dead ? to_state(3) : to_state(hsw + 1);
    h_as   = to_state(hds);
    h_ae   = to_state(hds + hact);
    v_last = to_state(vt - 1);
    v_on   = to_state(0);
    v_off  = to_state(vsw);
    v_as   = to_state(vds);
    v_ae   = to_state(vds + vact);
    repeat (3) @(negedge clk);
    // R1: quiet while reset is held
    chk("R1 hsync in reset", hs, 1'b0);
    chk("R1 vsync in reset", vs, 1'b0);
    chk("R1 de in reset", de, 1'b0);
    chk("R1 frame_start in reset", fs, 1'b0);
    rst_n = 1'b1;
    for (int c = 0; c < ht * vt * nframes; c++) begin
      if (ctrl_mode == 1 && (c % 37) == 0) ctrl = pick_ctrl(c / 37);
      en   = (ctrl == 8'h00);
      e_hs = en && !hs_dead && (p >= 1) && (p <= hsw);
      e_vs = en && (l < vsw);
      e_de = en && (p >= hds) && (p < hds + hact) && (l >= vds) && (l < vds + vact);
      e_fs = (p == 0) && (l == 0);
      @(posedge clk);
      if (p == ht - 1) begin
        p = 0;
        l = (l == vt - 1) ? 0 : l + 1;
      end else p++;
      @(negedge clk);
      chk(hs_dead ? "R10 hsync equal limits" : (en ? "R3 R5 R11 hsync" : "R8 hsync idle"), hs, e_hs);
      chk(en ? "R4 R6 vsync" : "R8 vsync idle", vs, e_vs);
      chk(en ? "R7 R2 de" : "R8 de idle", de, e_de);
      chk("R9 R1 frame_start", fs, e_fs);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    // directed: smallest rasters, both wraps every few cycles
    run_cfg(8, 1, 3, 4, 4, 1, 1, 2, 1'b0, 3, 0);
    run_cfg(12, 2, 4, 6, 6, 2, 3, 2, 1'b0, 2, 0);
    // equal start/stop: clear must win
    run_cfg(20, 3, 6, 10, 8, 1, 2, 4, 1'b1, 2, 0);
    // control code toggling mid-frame
    run_cfg(24, 2, 5, 12, 10, 2, 3, 5, 1'b0, 3, 1);
    // constrained random rasters
    for (int k = 0; k < 8; k++) begin
      int ht   = 16 + int'($urandom % 48);
      int hsw  = 1 + int'($urandom % 4);
      int hds  = hsw + 2 + int'($urandom % 3);
      int hact = 1 + int'($urandom % (ht - hds - 1));
      int vt   = 6 + int'($urandom % 12);
      int vsw  = 1 + int'($urandom % 2);
      int vds  = vsw + 1;
      int vact = 1 + int'($urandom % (vt - vds - 1));
      run_cfg(ht, hsw, hds, hact, vt, vsw, vds, vact, 1'b0, 2, k % 2);
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule